// File: doc/BRIEF.md
# GCR Sync Detector and Byte Clock

This block sits on the serial bit stream of a group-coded floppy channel. One bit arrives on each cycle that the bit strobe is high. The block keeps a window of the most recent bits and raises a sync flag while the last ten bits are all ones. A bit counter groups the stream into bytes. When reading, every completed sync run clears the counter, so bytes are framed from the first zero bit that follows the run. A one-clock strobe then delivers each framed byte from the read shift register.

When writing, the same counter runs freely and is never cleared. A write request stays pending until the counter next reaches the end of a byte. At that point a one-clock write-start strobe fires and the write shift register loads the parallel byte. The byte then leaves the block on the serial write output, most significant bit first. The counter keeps its value across mode changes.

Top module: `gcr_sync_framer`

## Requirements
- R1: `sync_found` is high in the cycle after a bit strobe whose bit completes ten consecutive ones. It stays high while further one bits arrive.
- R2: `sync_found` drops in the cycle after the bit strobe that carries the first zero following the run.
- R3: In read mode, a bit that completes a sync run clears the bit counter. The first zero after the run becomes the most significant bit (bit 7) of the next byte.
- R4: In read mode, after every eighth framed bit `byte_ready` is high for exactly one clock. In that clock `byte_data` holds those eight bits, the earliest at bit 7.
- R5: `byte_ready` is never high while `sync_found` is high. The bit that completes or extends a sync run delivers no byte.
- R6: In write mode the bit counter is never cleared by a sync run. It advances by one on every bit strobe and wraps after eight bits.
- R7: In write mode `wr_start` pulses for one clock after the first byte-boundary bit (the eighth count) at or after the cycle in which `wr_req` was seen.
- R8: With `wr_start`, the write shift register loads `wr_data`. `wr_bit` shows bit 7 of that byte, then shifts one place per bit strobe, filling with zeros.
- R9: In read mode `wr_req` has no effect: `wr_start` stays low, and the request is not remembered into a later write mode.
- R10: After reset, `sync_found`, `byte_ready`, `byte_data`, `wr_start` and `wr_bit` are zero and the bit counter starts at zero.
- R11: `byte_ready` never pulses in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit strobe, one serial bit per high cycle |
| bit_in | input | 1 | Serial read bit, valid with `bit_en` |
| mode_write | input | 1 | 0 selects read framing, 1 selects write mode |
| wr_req | input | 1 | Request to start writing at the next byte boundary |
| wr_data | input | 8 | Byte loaded into the write shift register at write start |
| sync_found | output | 1 | Last ten bits were ones |
| byte_ready | output | 1 | One-clock strobe, framed byte available |
| byte_data | output | 8 | Last framed byte |
| wr_start | output | 1 | One-clock strobe, writing begins |
| wr_bit | output | 1 | Serial write bit, MSB first |

## Verification
The assertions assume that `bit_in` matters only in cycles where `bit_en` is high. They also assume that `mode_write` and `wr_req` change only between bit strobes, or together with the bit they refer to. The bench drives every input on the falling edge. It gives each bit a single strobe cycle followed by idle cycles. A request is raised only in the same cycle as a bit strobe, so each request belongs to one known bit. Long ones runs are fed only where the test is about sync.

// File: rtl/gcr_sync_pkg.sv
package gcr_sync_pkg;

  // Operating direction of the channel.
  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } gsd_mode_e;

  // Default geometry.
  localparam int unsigned DEF_SYNC_LEN = 10;
  localparam int unsigned DEF_BYTE_W   = 8;

endpackage

// File: rtl/gsd_sync_window.sv
module gsd_sync_window #(
  parameter int unsigned SYNC_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic sync_found,
  output logic sync_hit
);

  logic [SYNC_LEN-1:0] hist_q;
  logic [SYNC_LEN-1:0] next_hist;
  logic [SYNC_LEN-1:0] run_and;

  assign next_hist = {hist_q[SYNC_LEN-2:0], bit_in};

  // Wide AND over the incoming window, built as a chain.
  assign run_and[0] = next_hist[0];
  for (genvar g = 1; g < SYNC_LEN; g++) begin : g_and_chain
    assign run_and[g] = run_and[g-1] & next_hist[g];
  end

  assign sync_hit = bit_en & run_and[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (bit_en) begin
      hist_q <= next_hist;
    end
  end

  assign sync_found = &hist_q;

endmodule

// File: rtl/gsd_byte_counter.sv
module gsd_byte_counter #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             boundary
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  function automatic logic [CNT_W-1:0] wrap_inc(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + CNT_W'(1);
  endfunction

  assign boundary = bit_en & (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (bit_en) begin
      count <= clear ? '0 : wrap_inc(count);
    end
  end

endmodule

// File: rtl/gsd_read_shifter.sv
module gsd_read_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              deliver,
  output logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data
);

  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] sr_next;

  assign sr_next = {sr_q[BYTE_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      byte_ready <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_ready <= deliver;
      if (bit_en) begin
        sr_q <= sr_next;
      end
      if (deliver) begin
        byte_data <= sr_next;
      end
    end
  end

endmodule

// File: rtl/gsd_write_shifter.sv
module gsd_write_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              write_mode,
  input  logic              wr_req,
  input  logic              boundary,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              start_now,
  output logic              wr_start,
  output logic              wr_bit
);

  logic              pending_q;
  logic [BYTE_W-1:0] sr_q;

  assign start_now = write_mode & boundary & (pending_q | wr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      wr_start  <= 1'b0;
      sr_q      <= '0;
    end else begin
      wr_start <= start_now;
      if (!write_mode || start_now) begin
        pending_q <= 1'b0;
      end else if (wr_req) begin
        pending_q <= 1'b1;
      end
      if (start_now) begin
        sr_q <= wr_data;
      end else if (bit_en) begin
        sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign wr_bit = sr_q[BYTE_W-1];

endmodule

// File: rtl/gcr_sync_framer.sv
module gcr_sync_framer #(
  parameter int unsigned SYNC_LEN = gcr_sync_pkg::DEF_SYNC_LEN,
  parameter int unsigned BYTE_W   = gcr_sync_pkg::DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              mode_write,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              sync_found,
  output logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data,
  output logic              wr_start,
  output logic              wr_bit
);

  import gcr_sync_pkg::*;

  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  gsd_mode_e        mode;
  logic             sync_hit;
  logic             cnt_clear;
  logic [CNT_W-1:0] bit_count;
  logic             boundary;
  logic             deliver;
  logic             start_now;

  assign mode      = gsd_mode_e'(mode_write);
  // Read framing restarts on sync; write framing free-runs.
  assign cnt_clear = (mode == MODE_READ) & sync_hit;
  assign deliver   = (mode == MODE_READ) & boundary & ~sync_hit;

  gsd_sync_window #(.SYNC_LEN(SYNC_LEN)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .sync_found (sync_found),
    .sync_hit   (sync_hit)
  );

  gsd_byte_counter #(.BYTE_W(BYTE_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .clear    (cnt_clear),
    .count    (bit_count),
    .boundary (boundary)
  );

  gsd_read_shifter #(.BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .deliver    (deliver),
    .byte_ready (byte_ready),
    .byte_data  (byte_data)
  );

  gsd_write_shifter #(.BYTE_W(BYTE_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .write_mode (mode == MODE_WRITE),
    .wr_req     (wr_req),
    .boundary   (boundary),
    .wr_data    (wr_data),
    .start_now  (start_now),
    .wr_start   (wr_start),
    .wr_bit     (wr_bit)
  );

endmodule

// File: rtl/gcr_sync_framer_chk.sv
module gcr_sync_framer_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             bit_in,
  input logic             mode_write,
  input logic             sync_found,
  input logic             sync_hit,
  input logic             byte_ready,
  input logic             wr_start,
  input logic [CNT_W-1:0] bit_count
);

  // R1
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_found) |-> ($past(bit_en) && $past(bit_in)));

  // R2
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_found) |-> ($past(bit_en) && !$past(bit_in)));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !mode_write) |=> (bit_count == '0));

  // R4
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |=> !byte_ready);

  // R5
  no_byte_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !sync_found);

  // R6
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode_write && bit_count != '1) |=> (bit_count == $past(bit_count) + 1'b1));

  // R7
  wr_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  // R9
  wr_start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> ($past(mode_write) && $past(bit_en)));

  // R11
  byte_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (!$past(mode_write) && $past(bit_en)));

endmodule

bind gcr_sync_framer gcr_sync_framer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .bit_in     (bit_in),
  .mode_write (mode_write),
  .sync_found (sync_found),
  .sync_hit   (sync_hit),
  .byte_ready (byte_ready),
  .wr_start   (wr_start),
  .bit_count  (bit_count)
);

// File: tb/gcr_sync_framer_test.sv
module gcr_sync_framer_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_GAP   = 3;
  localparam int NVEC       = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       mode_write = 1'b0;
  logic       wr_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sync_found, byte_ready, wr_start, wr_bit;
  logic [7:0] byte_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, kept from the requirements.
  logic [9:0] m_hist = '0;
  int         m_cnt = 0;
  bit         m_pend = 1'b0;
  logic [7:0] m_rsr = '0;
  logic [7:0] m_wsr = '0;
  logic [7:0] m_data = '0;
  bit         e_sync, e_br, e_ws;

  // Stimulus table: {mode_write, bit, wr_req}.
  localparam logic [2:0] VEC [0:NVEC-1] = '{
    3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010,
    3'b010, 3'b010, 3'b010, 3'b000, 3'b010, 3'b000, 3'b010, 3'b010,
    3'b000, 3'b000, 3'b010, 3'b001, 3'b010, 3'b010, 3'b000, 3'b000,
    3'b100, 3'b110, 3'b101, 3'b100, 3'b110, 3'b110, 3'b100, 3'b100,
    3'b110, 3'b100, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
    3'b110, 3'b110, 3'b111, 3'b110, 3'b100, 3'b100, 3'b100, 3'b100
  };

  gcr_sync_framer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .mode_write (mode_write),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .sync_found (sync_found),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .wr_start   (wr_start),
    .wr_bit     (wr_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model step for one bit.
  task automatic model(input bit wm, input bit b, input bit rq);
    bit sync_now;
    bit bnd;
    sync_now = (m_hist[8:0] == 9'h1FF) && b;
    bnd      = (m_cnt == 7);
    m_hist   = {m_hist[8:0], b};
    e_sync   = (m_hist == 10'h3FF);
    e_br     = 1'b0;
    e_ws     = 1'b0;
    if (!wm) begin
      m_pend = 1'b0;
      if (sync_now) m_cnt = 0;
      else begin
        if (bnd) begin e_br = 1'b1; m_data = {m_rsr[6:0], b}; end
        m_cnt = (m_cnt + 1) % 8;
      end
    end else begin
      if (bnd && (m_pend || rq)) begin e_ws = 1'b1; m_pend = 1'b0; end
      else if (rq) m_pend = 1'b1;
      m_cnt = (m_cnt + 1) % 8;
    end
    m_rsr = {m_rsr[6:0], b};
    m_wsr = e_ws ? wr_data : {m_wsr[6:0], 1'b0};
  endtask

  // One bit strobe, then idle cycles; all checks away from the edge.
  task automatic send(input bit wm, input bit b, input bit rq, input string tag);
    @(negedge clk);
    mode_write = wm; bit_en = 1'b1; bit_in = b; wr_req = rq;
    model(wm, b, rq);
    @(negedge clk);
    bit_en = 1'b0; wr_req = 1'b0; bit_in = 1'b0;
    check(e_sync ? "R1" : "R2", {tag, " sync_found"}, 8'(sync_found), 8'(e_sync));
    check(wm ? "R11" : (e_sync ? "R5" : "R4"), {tag, " byte_ready"}, 8'(byte_ready), 8'(e_br));
    if (e_br) check("R4", {tag, " byte_data"}, byte_data, m_data);
    check(wm ? "R7" : "R9", {tag, " wr_start"}, 8'(wr_start), 8'(e_ws));
    check("R8", {tag, " wr_bit"}, 8'(wr_bit), 8'(m_wsr[7]));
    for (int i = 0; i < IDLE_GAP - 1; i++) @(negedge clk);
    check("R4", {tag, " byte_ready idle"}, 8'(byte_ready), 8'h00);
    check("R7", {tag, " wr_start idle"}, 8'(wr_start), 8'h00);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit got;
    logic [7:0] pat;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "sync_found reset", 8'(sync_found), 8'h00);
    check("R10", "byte_ready reset", 8'(byte_ready), 8'h00);
    check("R10", "byte_data reset", byte_data, 8'h00);
    check("R10", "wr_start reset", 8'(wr_start), 8'h00);
    check("R10", "wr_bit reset", 8'(wr_bit), 8'h00);
    rst_n = 1'b1;

    // Table walk.
    wr_data = 8'hC3;
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][2], VEC[v][1], VEC[v][0], $sformatf("vec%0d", v));
    end

    // R1 R3 R4 R5: long sync run then literal byte 0x4B.
    for (int i = 0; i < 15; i++) send(1'b0, 1'b1, 1'b0, "r1_run");
    check("R1", "sync held in long run", 8'(sync_found), 8'h01);
    pat = 8'h4B;
    got = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      send(1'b0, pat[i], 1'b0, "r3_byte");
      if (i == 7) check("R2", "sync drops on first zero", 8'(sync_found), 8'h00);
    end
    check("R3", "framed byte after sync", byte_data, 8'h4B);

    // R9: request in read mode, then idle in write mode for a full byte.
    send(1'b0, 1'b0, 1'b1, "r9_req");
    got = 1'b0;
    for (int i = 0; i < 9; i++) begin
      send(1'b1, 1'b0, 1'b0, "r9_after");
      if (wr_start) got = 1'b1;
    end
    check("R9", "read-mode request dropped", 8'(got), 8'h00);

    // R6 R7 R8: sync run in write mode must not reframe the count.
    wr_data = 8'hA6;
    for (int i = 0; i < 12; i++) send(1'b1, 1'b1, (i == 3), "r6_sync");
    for (int i = 0; i < 10; i++) send(1'b1, 1'b0, 1'b0, "r8_shift");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule